// File: doc/BRIEF.md
# Programmable-Skew Clock Output Matrix

This block is a cycle-level digital model of a four-group clock output stage. It runs from a fast tick clock. One tick is one time unit, and one nominal output period is N ticks. A range select picks N from three values. A free-running modulo-N counter defines the zero-phase point, and every output waveform is derived from that one counter.

Each group drives a pair of outputs that always carry the same waveform. Each group also reads two three-level select codes. Groups 1 and 2 turn these codes into a signed phase shift of up to four time units. Groups 3 and 4 shift in steps of two time units, up to six. The two corner codes of groups 3 and 4 give divide-by-two or divide-by-four outputs, and on group 4 one corner code gives an inverted output.

A test select moves the block from the Run state to the Bypass state. In Bypass the outputs follow a reference input instead of the counter. Every configuration input is sampled only when the counter wraps, so a change never cuts a pulse short.

The control state machine has two states:
- **Run**: outputs come from the tick counter.
- **Bypass**: outputs come from the registered reference input.

It has three transitions, all taken only on a counter wrap:
- Run to Bypass, when the test select reads MID or HIGH.
- Bypass to Run, when the test select reads LOW or the unassigned code.
- Staying in the current state, on any cycle that is not a wrap.

Top module: `skew_clk_matrix`

## Requirements
- R1: The two outputs of a group (bits 2g and 2g+1 of `q_o`, with g = 0 for group 1) are equal on every cycle.
- R2: The period N is set by range code 00 (LOW) = 44 ticks, 01 (MID) = 26, 10 (HIGH) = 16, and 11 = 26. The tick counter runs from 0 to N-1 and then wraps to 0.
- R3: The selects, range and test inputs are sampled only on the cycle the counter wraps. The period that is already running keeps its old N and its old functions.
- R4: Level codes are 00 = LOW, 01 = MID, 10 = HIGH. Group g reads select0 at `grp_sel_i[4g+1:4g]` and select1 at `grp_sel_i[4g+3:4g+2]`. With idx = 3·select1 + select0, groups 1 and 2 shift by idx−4 time units, from −4 (both LOW) to +4 (both HIGH).
- R5: Groups 3 and 4 shift by 2·(idx−4) time units for idx 1 to 7, which covers −6 to +6. Both MID gives zero skew, and select0 MID with select1 HIGH gives +6.
- R6: In Run, an output with shift k goes high when the counter equals k mod N and stays high for N/2 ticks.
- R7: Group 3 with both selects LOW divides by four, and with both HIGH divides by two. Group 4 with both selects LOW divides by two. A 2-bit period count advances on each wrap in Run. The divide-by-two output is high while bit 0 of that count is 1, and the divide-by-four output is high while bit 1 is 1.
- R8: Group 4 with both selects HIGH gives an inverted zero-phase output: low for the first N/2 ticks of each period and high for the rest.
- R9: The divide-by-two and divide-by-four outputs fall on the same tick whenever the divide-by-four output falls.
- R10: A select code of 11 in either select of a group gives zero skew on that group.
- R11: In Bypass, shifted groups output the reference input registered once, and the inverted group outputs its complement. The divided groups count rising edges of the reference instead of counter wraps.
- R12: Reset sets the counter to 0 with N = 26, all groups to zero skew, and the Run state, so every output is high while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Time-unit tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| range_sel_i | input | 2 | Range select level code, which picks N |
| test_sel_i | input | 2 | Test select level code; MID or HIGH selects Bypass |
| ref_i | input | 1 | Reference input used in Bypass |
| grp_sel_i | input | 16 | Two 2-bit level codes per group; group g uses bits 4g+3:4g |
| q_o | output | 8 | Two identical outputs per group; group g drives bits 2g+1:2g |

## Verification
The bench changes the range in the middle of a period. A design that applied the new range at once would produce a period whose length is neither the old N nor the new one. The bench also places unassigned codes on the selects; a decoder that read those codes as LOW would move the rising edge of the group away from counter zero. It watches the divide-by-two and divide-by-four pair for a shared falling edge, which a divider clocked from the wrong period count would miss by a full period. It toggles the reference in Bypass and expects the divided outputs to count reference edges instead of counter wraps.

// File: rtl/skew_pkg.sv
package skew_pkg;

    // Three-level select code as seen on the pins.
    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_BAD  = 2'b11
    } lvl_t;

    // Waveform produced by one group.
    typedef enum logic [1:0] {
        FN_SKEW = 2'd0,
        FN_DIV2 = 2'd1,
        FN_DIV4 = 2'd2,
        FN_INV  = 2'd3
    } fn_t;

    // Source of the outputs.
    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_BYPASS = 1'b1
    } mode_t;

    typedef struct packed {
        fn_t                fn;
        logic signed [3:0]  off;
    } gfn_t;

endpackage

// File: rtl/skew_tick_ctr.sv
module skew_tick_ctr
    import skew_pkg::*;
#(
    parameter int N_LOW  = 44,
    parameter int N_MID  = 26,
    parameter int N_HIGH = 16,
    parameter int CW     = 6,
    parameter int SW     = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [1:0]    range_i,
    input  logic [1:0]    test_i,
    input  logic          ref_i,
    input  logic [SW-1:0] sel_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] n_o,
    output logic [CW-1:0] half_o,
    output logic [1:0]    ecnt_o,
    output mode_t         mode_o,
    output logic          refq_o,
    output logic [SW-1:0] sel_o
);

    localparam logic [SW-1:0] SEL_RST = {(SW/2){LVL_MID}};

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] n_q;
    logic [CW-1:0] n_sel;
    logic [SW-1:0] sel_q;
    logic [1:0]    ecnt_q;
    logic          refq_q;
    logic          wrap;
    logic          ref_rise;
    logic          ecnt_inc;
    mode_t         mode_q;
    mode_t         mode_d;

    // Period length for the range code at the pins.
    always_comb begin
        unique case (lvl_t'(range_i))
            LVL_LOW:  n_sel = CW'(N_LOW);
            LVL_MID:  n_sel = CW'(N_MID);
            LVL_HIGH: n_sel = CW'(N_HIGH);
            LVL_BAD:  n_sel = CW'(N_MID);
        endcase
    end

    assign wrap     = (cnt_q == n_q - 1'b1);
    assign ref_rise = ref_i & ~refq_q;

    // State register of the Run/Bypass machine.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mode_q <= ST_RUN;
        else         mode_q <= mode_d;
    end

    // Next state and the event that advances the divider count.
    always_comb begin
        mode_d = mode_q;
        if (wrap) begin
            unique case (lvl_t'(test_i))
                LVL_MID, LVL_HIGH: mode_d = ST_BYPASS;
                LVL_LOW, LVL_BAD:  mode_d = ST_RUN;
            endcase
        end
        unique case (mode_q)
            ST_RUN:    ecnt_inc = wrap;
            ST_BYPASS: ecnt_inc = ref_rise;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            n_q    <= CW'(N_MID);
            sel_q  <= SEL_RST;
            ecnt_q <= '0;
            refq_q <= 1'b0;
        end else begin
            refq_q <= ref_i;
            if (ecnt_inc) ecnt_q <= ecnt_q + 2'd1;
            if (wrap) begin
                cnt_q <= '0;
                n_q   <= n_sel;
                sel_q <= sel_i;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign n_o    = n_q;
    assign half_o = n_q >> 1;
    assign ecnt_o = ecnt_q;
    assign mode_o = mode_q;
    assign refq_o = refq_q;
    assign sel_o  = sel_q;

    // R2: the counter never reaches the active period length
    p_cnt_below_n_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q < n_q);

    // R2: the active period is always one of the three lengths
    p_n_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (n_q == CW'(N_LOW)) || (n_q == CW'(N_MID)) || (n_q == CW'(N_HIGH)));

    // R3: configuration moves only after a wrap
    p_cfg_only_at_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(wrap) |-> ($stable(sel_q) && $stable(n_q) && $stable(mode_q)));

    // R9: whenever the divide-by-four bit falls, the divide-by-two bit falls too
    p_div_shared_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ecnt_q[1]) |-> $fell(ecnt_q[0]));

endmodule

// File: rtl/skew_fn_dec.sv
module skew_fn_dec
    import skew_pkg::*;
#(
    parameter int GRP = 0
) (
    input  logic [1:0] s0_i,
    input  logic [1:0] s1_i,
    output gfn_t       fn_o
);

    logic       bad;
    logic [3:0] idx;

    assign bad = (lvl_t'(s0_i) == LVL_BAD) || (lvl_t'(s1_i) == LVL_BAD);
    assign idx = 4'(3 * int'(s1_i) + int'(s0_i));

    generate
        if (GRP < 2) begin : g_plain
            // Single time-unit steps, -4 .. +4.
            always_comb begin
                fn_o.fn  = FN_SKEW;
                fn_o.off = bad ? 4'sd0 : 4'(int'(idx) - 4);
            end
        end else begin : g_ext
            // Two time-unit steps with corner functions.
            always_comb begin
                fn_o.fn  = FN_SKEW;
                fn_o.off = 4'sd0;
                if (!bad) begin
                    if (idx == 4'd0) begin
                        fn_o.fn = (GRP == 2) ? FN_DIV4 : FN_DIV2;
                    end else if (idx == 4'd8) begin
                        fn_o.fn = (GRP == 2) ? FN_DIV2 : FN_INV;
                    end else begin
                        fn_o.off = 4'(2 * (int'(idx) - 4));
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/skew_wave_gen.sv
module skew_wave_gen
    import skew_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  gfn_t          fn_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] n_i,
    input  logic [CW-1:0] half_i,
    input  logic [1:0]    ecnt_i,
    input  mode_t         mode_i,
    input  logic          refq_i,
    output logic          q_o
);

    logic [3:0]    mag;
    logic [CW-1:0] km;
    logic [CW-1:0] rel;
    logic          in_hi;

    // Rising point k mod N, then the distance of the counter past it.
    assign mag   = fn_i.off[3] ? 4'(-fn_i.off) : 4'(fn_i.off);
    assign km    = fn_i.off[3] ? (n_i - CW'(mag)) : CW'(mag);
    assign rel   = (cnt_i >= km) ? (cnt_i - km) : (cnt_i + (n_i - km));
    assign in_hi = (rel < half_i);

    always_comb begin
        unique case (mode_i)
            ST_RUN: begin
                unique case (fn_i.fn)
                    FN_SKEW: q_o = in_hi;
                    FN_DIV2: q_o = ecnt_i[0];
                    FN_DIV4: q_o = ecnt_i[1];
                    FN_INV:  q_o = ~(cnt_i < half_i);
                endcase
            end
            ST_BYPASS: begin
                unique case (fn_i.fn)
                    FN_SKEW: q_o = refq_i;
                    FN_DIV2: q_o = ecnt_i[0];
                    FN_DIV4: q_o = ecnt_i[1];
                    FN_INV:  q_o = ~refq_i;
                endcase
            end
        endcase
    end

    // R6: a zero-skew output in Run only rises at counter zero
    p_zero_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == ST_RUN && fn_i.fn == FN_SKEW && fn_i.off == 4'sd0 && $rose(q_o))
        |-> (cnt_i == '0));

endmodule

// File: rtl/skew_clk_matrix.sv
module skew_clk_matrix
    import skew_pkg::*;
#(
    parameter int N_LOW  = 44,
    parameter int N_MID  = 26,
    parameter int N_HIGH = 16,
    parameter int NGRP   = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        range_sel_i,
    input  logic [1:0]        test_sel_i,
    input  logic              ref_i,
    input  logic [4*NGRP-1:0] grp_sel_i,
    output logic [2*NGRP-1:0] q_o
);

    localparam int NMAX = (N_LOW > N_MID) ? ((N_LOW > N_HIGH) ? N_LOW : N_HIGH)
                                          : ((N_MID > N_HIGH) ? N_MID : N_HIGH);
    localparam int CW   = $clog2(NMAX + 1);
    localparam int SW   = 4 * NGRP;

    logic [CW-1:0] cnt;
    logic [CW-1:0] n_act;
    logic [CW-1:0] half;
    logic [1:0]    ecnt;
    logic          refq;
    logic [SW-1:0] sel_act;
    mode_t         mode;

    skew_tick_ctr #(
        .N_LOW (N_LOW),
        .N_MID (N_MID),
        .N_HIGH(N_HIGH),
        .CW    (CW),
        .SW    (SW)
    ) u_ctr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .range_i(range_sel_i),
        .test_i (test_sel_i),
        .ref_i  (ref_i),
        .sel_i  (grp_sel_i),
        .cnt_o  (cnt),
        .n_o    (n_act),
        .half_o (half),
        .ecnt_o (ecnt),
        .mode_o (mode),
        .refq_o (refq),
        .sel_o  (sel_act)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        gfn_t fn;
        logic wave;

        skew_fn_dec #(.GRP(g)) u_dec (
            .s0_i(sel_act[4*g +: 2]),
            .s1_i(sel_act[4*g+2 +: 2]),
            .fn_o(fn)
        );

        skew_wave_gen #(.CW(CW)) u_wave (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .fn_i  (fn),
            .cnt_i (cnt),
            .n_i   (n_act),
            .half_i(half),
            .ecnt_i(ecnt),
            .mode_i(mode),
            .refq_i(refq),
            .q_o   (wave)
        );

        assign q_o[2*g]   = wave;
        assign q_o[2*g+1] = wave;
    end

endmodule

// File: tb/skew_clk_matrix_tb_top.sv
module skew_clk_matrix_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  range_sel;
    logic [1:0]  test_sel;
    logic        ref_in;
    logic [15:0] grp_sel;
    logic [7:0]  q;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference model state, advanced on each rising edge.
    int         m_cnt, m_n, m_mode, m_ecnt;
    logic       m_refq;
    logic [15:0] m_sel;

    always #(CLK_PERIOD/2) clk = ~clk;

    skew_clk_matrix dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .range_sel_i(range_sel),
        .test_sel_i (test_sel),
        .ref_i      (ref_in),
        .grp_sel_i  (grp_sel),
        .q_o        (q)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_n = 26; m_sel = 16'h5555; m_mode = 0; m_ecnt = 0; m_refq = 0;
        end else begin
            bit wrap;
            bit inc;
            wrap = (m_cnt == m_n - 1);
            inc  = m_mode ? (ref_in && !m_refq) : wrap;
            m_refq = ref_in;
            if (inc) m_ecnt = (m_ecnt + 1) % 4;
            if (wrap) begin
                m_cnt  = 0;
                m_n    = (range_sel == 2'b00) ? 44 : (range_sel == 2'b10) ? 16 : 26;
                m_sel  = grp_sel;
                m_mode = (test_sel == 2'b01 || test_sel == 2'b10) ? 1 : 0;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    end

    // Expected output of group g from the requirements.
    function automatic logic exp_bit(input int g, output string tag);
        int s0, s1, idx, k, fn, km, rel;
        s0 = int'(m_sel[4*g +: 2]);
        s1 = int'(m_sel[4*g+2 +: 2]);
        k = 0; fn = 0;
        tag = (g < 2) ? "R4" : "R5";
        if (s0 == 3 || s1 == 3) begin
            tag = "R10";
        end else begin
            idx = 3*s1 + s0;
            if (g < 2)          k = idx - 4;
            else if (idx == 0)  fn = (g == 2) ? 2 : 1;
            else if (idx == 8)  fn = (g == 2) ? 1 : 3;
            else                k = 2*(idx - 4);
        end
        if (fn == 1 || fn == 2) tag = "R7";
        if (fn == 3) tag = "R8";
        if (fn == 1) return logic'(m_ecnt % 2);
        if (fn == 2) return logic'(m_ecnt / 2);
        if (m_mode != 0) begin
            tag = "R11";
            return (fn == 3) ? !m_refq : m_refq;
        end
        if (fn == 3) return !(m_cnt < m_n/2);
        km  = (k + m_n) % m_n;
        rel = (m_cnt - km + m_n) % m_n;
        return rel < m_n/2;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_cycle();
        for (int g = 0; g < 4; g++) begin
            string tag;
            logic e;
            e = exp_bit(g, tag);
            chk(q[2*g] === e, tag, int'(q[2*g]), int'(e));
            chk(q[2*g+1] === q[2*g], "R1", int'(q[2*g+1]), int'(q[2*g]));
        end
    endtask

    task automatic tick();
        @(negedge clk);
        check_cycle();
    endtask

    task automatic set_grp(input int g, input logic [1:0] s0, input logic [1:0] s1);
        grp_sel[4*g +: 2]   = s0;
        grp_sel[4*g+2 +: 2] = s1;
    endtask

    task automatic wait_rise();
        logic last;
        last = q[0];
        tick();
        while (!(q[0] && !last)) begin
            last = q[0];
            tick();
        end
    endtask

    // Starting on a rising cycle of q[0], measure ticks to the next rise.
    task automatic run_period(output int per, output int hi);
        logic last;
        per = 0; hi = 0;
        do begin
            if (q[0]) hi++;
            last = q[0];
            tick();
            per++;
        end while (!(q[0] && !last));
    endtask

    task automatic wait_wrap();
        tick();
        while (m_cnt != 0) tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int per, hi, falls, ref_left;
        logic p2, p4;
        void'($urandom(32'h5EED_0417));
        rst_n = 0; range_sel = 2'b01; test_sel = 2'b00; ref_in = 0; grp_sel = 16'h5555;

        // R12: reset state
        repeat (3) @(negedge clk);
        chk(q === 8'hFF, "R12", int'(q), 255);
        rst_n = 1;
        tick();
        chk(q === 8'hFF, "R12", int'(q), 255);

        // R2 / R6: period and high time for every range code
        for (int r = 0; r < 4; r++) begin
            int expn;
            expn = (r == 0) ? 44 : (r == 2) ? 16 : 26;
            range_sel = 2'(r);
            wait_rise();
            run_period(per, hi);
            chk(per == expn, "R2", per, expn);
            chk(hi == expn/2, "R6", hi, expn/2);
        end

        // R3: a range change in mid-period waits for the wrap
        range_sel = 2'b00;
        run_period(per, hi);
        chk(per == 26, "R3", per, 26);
        run_period(per, hi);
        chk(per == 44, "R3", per, 44);

        // R10: unassigned code gives zero skew on groups 1 and 3
        range_sel = 2'b10;
        set_grp(0, 2'b11, 2'b00);
        set_grp(2, 2'b01, 2'b11);
        wait_wrap(); wait_wrap();
        for (int i = 0; i < 16; i++) begin
            chk(q[0] === (m_cnt < 8), "R10", int'(q[0]), int'(m_cnt < 8));
            chk(q[4] === (m_cnt < 8), "R10", int'(q[4]), int'(m_cnt < 8));
            tick();
        end

        // R8: group 4 inverted against zero-skew group 1
        set_grp(0, 2'b01, 2'b01);
        set_grp(3, 2'b10, 2'b10);
        wait_wrap(); wait_wrap();
        for (int i = 0; i < 16; i++) begin
            chk(q[6] === ~q[0], "R8", int'(q[6]), int'(~q[0]));
            tick();
        end

        // R9: divide-by-four on group 3, divide-by-two on group 4
        set_grp(2, 2'b00, 2'b00);
        set_grp(3, 2'b00, 2'b00);
        wait_wrap(); wait_wrap();
        falls = 0;
        p2 = q[6]; p4 = q[4];
        for (int i = 0; i < 16*10; i++) begin
            tick();
            if (p4 && !q[4]) begin
                falls++;
                chk(p2 && !q[6], "R9", int'(q[6]), 0);
            end
            p2 = q[6]; p4 = q[4];
        end
        chk(falls >= 2, "R9", falls, 2);

        // R11: bypass follows the reference one tick later
        test_sel = 2'b01;
        set_grp(0, 2'b10, 2'b10);
        wait_wrap(); tick();
        for (int i = 0; i < 6; i++) begin
            ref_in = ~ref_in;
            tick();
            chk(q[0] === ref_in, "R11", int'(q[0]), int'(ref_in));
        end
        test_sel = 2'b00;

        // Random configurations checked every cycle against the model.
        ref_left = 3;
        for (int i = 0; i < 15000; i++) begin
            tick();
            if ($urandom_range(0, 59) == 0) grp_sel = 16'($urandom());
            if ($urandom_range(0, 199) == 0) range_sel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 149) == 0)
                test_sel = ($urandom_range(0, 9) < 6) ? 2'b00 : 2'($urandom_range(0, 3));
            ref_left--;
            if (ref_left == 0) begin
                ref_in = ~ref_in;
                ref_left = $urandom_range(2, 9);
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule